// File: doc/BRIEF.md
# Disc Controller Register Window

This block is the byte-wide register window of a disc data controller. A host reaches sixteen registers through a 4-bit index. Reads and writes at the same index reach different registers. After most accesses the index moves on by one, so a host can walk a group of registers with back-to-back accesses. Writes to some indices have side effects. They start a transfer, stop it, acknowledge its end, or return the window to its power-up contents.

Reads of the decoder-result registers are recorded in a tracking mask. The last status byte only reports "valid" (0x80) once a full set of those registers has been read and both enables are on. Header, status, command-in and interface-status bytes are loaded as whole values from the decoder side through a load strobe. The transfer state (busy, count, data address, end flag) is driven out to the host data port that moves the data.

Top module: `disc_ctl_regwin`

## Requirements
- R1: After rst_n, the read map at index 0..15 returns 00, FF, 00, 00, 00, 00, 00, 01, 00, 00, 60, 12, 80, 00, 00, 00. At the same time ptr is 0, xfer_busy is 0, host_end is 1, and xfer_cnt, xfer_addr, sub_out and ctrl_out are 0.
- R2: Each read index returns a fixed register. 0 is command-in and 1 is interface status. 2/3 are the byte count (low/high). 4..7 are header bytes 0..3. 8/9 are the block pointer (low/high). 10/11 are the write address (low/high). 12..15 are status bytes 0..3.
- R3: Each write index sets a fixed register. 0 is sub-output (sub_out). 1 is interface control. 2/3 are the byte count (xfer_cnt). 4/5 are the data address (xfer_addr). 8/9 are the write address. 10, 11 and 14 are control bytes 0, 1 and 2 (ctrl_out bits 7:0, 15:8 and 23:16). 12/13 are the block pointer. In every multi-byte register the low byte sits at the lower index.
- R4: A read moves ptr to index+1, except that a read of index 15 leaves it at 15.
- R5: A write moves ptr to index+1, except that writes to indices 6, 7, 14 and 15 leave it unchanged.
- R6: While ptr_ld is high, ptr takes ptr_val and any read or write in that cycle is ignored. When rd_en and wr_en are both high, only the write takes place.
- R7: Reading index 1, 4..9 or 12..14 sets bit <index> of a tracking mask. Suppose index 15 is read while control byte 0 bit 7 and interface-control bit 5 are set, and the mask holds all of 0x73F2. Then that read returns the old status byte 3, and status byte 3 then becomes 0x80. Otherwise status byte 3 is unchanged.
- R8: A read of index 15 sets interface-status bit 5.
- R9: A write to index 1 with data bit 1 clear forces the byte count to 0, clears xfer_busy and sets interface-status bit 3.
- R10: A write to index 6 while interface-control bit 1 is set clears interface-status bit 3, sets xfer_busy and clears host_end. Otherwise the write to index 6 has no effect.
- R11: A write to index 7 sets interface-status bit 6.
- R12: A write to index 15 restores the R1 register values in one cycle and clears the tracking mask, overriding any other update in that cycle. ptr stays at 15 and host_end keeps its value.
- R13: dec_ld loads command-in, interface status, header bytes 0..3 and status bytes 0..3 from dec_cmd, dec_ifstat, dec_head and dec_stat. Byte n is bits 8n+7:8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_ld | input | 1 | Load the register index |
| ptr_val | input | 4 | Index value to load |
| rd_en | input | 1 | Read strobe at current index |
| wr_en | input | 1 | Write strobe at current index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data at current index |
| ptr | output | 4 | Current register index |
| dec_ld | input | 1 | Load decoder-side values |
| dec_cmd | input | 8 | Command-in value |
| dec_ifstat | input | 8 | Interface status value |
| dec_head | input | 32 | Header bytes 0..3 |
| dec_stat | input | 32 | Status bytes 0..3 |
| xfer_busy | output | 1 | Transfer in progress |
| host_end | output | 1 | Host end-of-transfer flag |
| xfer_cnt | output | 16 | Transfer byte count |
| xfer_addr | output | 16 | Transfer data address |
| sub_out | output | 8 | Sub-output byte |
| ctrl_out | output | 24 | Control bytes 2..0 |

## Verification
The bench repeats one pass once for each of the ten tracked registers, leaving that register out. A design that tracked the wrong index, or tested the mask loosely, would post 0x80 with a register unread, or never post it. The same pass is repeated with each enable dropped, which catches a design that posts the valid code without its gates. The bench also walks the pointer over all read and write indices. A wrong exception list shows up as a pointer that advances past 6, 7, 14 or 15, or that stalls elsewhere. A soft reset is checked for the registers it restores, for the pointer it must leave at 15, and for the host end flag it must leave alone. A trigger sent while transfers are disabled must leave xfer_busy low.

// File: rtl/disc_ctl_regwin.sv
module disc_ctl_regwin #(
  parameter logic [15:0] WADDR_INIT = 16'd4704,
  parameter logic [15:0] TRACK      = 16'h73F2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptr_ld,
  input  logic [3:0]  ptr_val,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [3:0]  ptr,
  input  logic        dec_ld,
  input  logic [7:0]  dec_cmd,
  input  logic [7:0]  dec_ifstat,
  input  logic [31:0] dec_head,
  input  logic [31:0] dec_stat,
  output logic        xfer_busy,
  output logic        host_end,
  output logic [15:0] xfer_cnt,
  output logic [15:0] xfer_addr,
  output logic [7:0]  sub_out,
  output logic [23:0] ctrl_out
);

  logic [7:0]  cmd_in, ifstat, ifctrl;
  logic [15:0] blk_ptr, wr_addr, rd_mask;
  logic [31:0] head, stat;

  wire acc_wr  = wr_en & ~ptr_ld;
  wire acc_rd  = rd_en & ~wr_en & ~ptr_ld;
  wire soft_rs = acc_wr & (ptr == 4'd15);
  wire wr_hold = (ptr == 4'd6) | (ptr == 4'd7) | (ptr == 4'd14) | (ptr == 4'd15);
  wire valid_go = ctrl_out[7] & ifctrl[5] & ((rd_mask & TRACK) == TRACK);

  always_comb begin
    case (ptr)
      4'd0:    rdata = cmd_in;
      4'd1:    rdata = ifstat;
      4'd2:    rdata = xfer_cnt[7:0];
      4'd3:    rdata = xfer_cnt[15:8];
      4'd4:    rdata = head[7:0];
      4'd5:    rdata = head[15:8];
      4'd6:    rdata = head[23:16];
      4'd7:    rdata = head[31:24];
      4'd8:    rdata = blk_ptr[7:0];
      4'd9:    rdata = blk_ptr[15:8];
      4'd10:   rdata = wr_addr[7:0];
      4'd11:   rdata = wr_addr[15:8];
      4'd12:   rdata = stat[7:0];
      4'd13:   rdata = stat[15:8];
      4'd14:   rdata = stat[23:16];
      default: rdata = stat[31:24];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      host_end  <= 1'b1;
      cmd_in    <= '0;
      ifstat    <= 8'hFF;
      xfer_cnt  <= '0;
      xfer_addr <= '0;
      head      <= 32'h0100_0000;
      blk_ptr   <= '0;
      wr_addr   <= WADDR_INIT;
      stat      <= 32'h0000_0080;
      sub_out   <= '0;
      ifctrl    <= '0;
      ctrl_out  <= '0;
      rd_mask   <= '0;
      xfer_busy <= 1'b0;
    end else begin
      if (dec_ld) begin
        cmd_in <= dec_cmd;
        ifstat <= dec_ifstat;
        head   <= dec_head;
        stat   <= dec_stat;
      end
      if (ptr_ld) begin
        ptr <= ptr_val;
      end else if (acc_wr) begin
        if (!wr_hold) ptr <= ptr + 4'd1;
        case (ptr)
          4'd0: sub_out <= wdata;
          4'd1: begin
            ifctrl <= wdata;
            if (!wdata[1]) begin
              xfer_cnt  <= '0;
              xfer_busy <= 1'b0;
              ifstat[3] <= 1'b1;
            end
          end
          4'd2:  xfer_cnt[7:0]    <= wdata;
          4'd3:  xfer_cnt[15:8]   <= wdata;
          4'd4:  xfer_addr[7:0]   <= wdata;
          4'd5:  xfer_addr[15:8]  <= wdata;
          4'd6: if (ifctrl[1]) begin
            ifstat[3] <= 1'b0;
            xfer_busy <= 1'b1;
            host_end  <= 1'b0;
          end
          4'd7:  ifstat[6]        <= 1'b1;
          4'd8:  wr_addr[7:0]     <= wdata;
          4'd9:  wr_addr[15:8]    <= wdata;
          4'd10: ctrl_out[7:0]    <= wdata;
          4'd11: ctrl_out[15:8]   <= wdata;
          4'd12: blk_ptr[7:0]     <= wdata;
          4'd13: blk_ptr[15:8]    <= wdata;
          4'd14: ctrl_out[23:16]  <= wdata;
          default: ;
        endcase
      end else if (acc_rd) begin
        if (ptr != 4'd15) ptr <= ptr + 4'd1;
        if (TRACK[ptr]) rd_mask[ptr] <= 1'b1;
        if (ptr == 4'd15) begin
          ifstat[5] <= 1'b1;
          if (valid_go) stat[31:24] <= 8'h80;
        end
      end
      if (soft_rs) begin
        cmd_in    <= '0;
        ifstat    <= 8'hFF;
        xfer_cnt  <= '0;
        xfer_addr <= '0;
        head      <= 32'h0100_0000;
        blk_ptr   <= '0;
        wr_addr   <= WADDR_INIT;
        stat      <= 32'h0000_0080;
        sub_out   <= '0;
        ifctrl    <= '0;
        ctrl_out  <= '0;
        rd_mask   <= '0;
        xfer_busy <= 1'b0;
      end
    end
  end

  // R5
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !wr_hold) |=> (ptr == $past(ptr) + 4'd1));

  // R4
  rd_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && ptr == 4'd15) |=> (ptr == 4'd15 && ifstat[5]));

  // R9
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && ptr == 4'd1 && !wdata[1]) |=> (!xfer_busy && xfer_cnt == 16'd0 && ifstat[3]));

  // R10
  trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && ptr == 4'd6 && ifctrl[1]) |=> (xfer_busy && !host_end && !ifstat[3]));

  // R11
  ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && ptr == 4'd7) |=> ifstat[6]);

  // R12
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rs |=> (ptr == 4'd15 && ifstat == 8'hFF && rd_mask == 16'd0 && !xfer_busy
                 && $stable(host_end) && wr_addr == WADDR_INIT));

  // R7
  valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && ptr == 4'd15 && valid_go && !dec_ld) |=> (stat[31:24] == 8'h80));

  // R6
  ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> (ptr == $past(ptr_val)));

endmodule

// File: tb/sim_disc_ctl_regwin.sv
module sim_disc_ctl_regwin;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ptr_ld = 0, rd_en = 0, wr_en = 0, dec_ld = 0;
  logic [3:0] ptr_val = '0;
  logic [7:0] wdata = '0, dec_cmd = '0, dec_ifstat = '0;
  logic [31:0] dec_head = '0, dec_stat = '0;
  logic [7:0] rdata, sub_out;
  logic [3:0] ptr;
  logic xfer_busy, host_end;
  logic [15:0] xfer_cnt, xfer_addr;
  logic [23:0] ctrl_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  disc_ctl_regwin u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_ptr(input logic [3:0] v);
    ptr_ld = 1; ptr_val = v; tick(); ptr_ld = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] exp, input bit chk);
    rd_en = 1; #1;
    if (chk) check(tag, rdata, exp);
    tick(); rd_en = 0;
  endtask

  task automatic rd_at(input logic [3:0] i, input string tag, input logic [7:0] exp);
    set_ptr(i); rd(tag, exp, 1);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wdata = d; tick(); wr_en = 0;
  endtask

  task automatic wr_at(input logic [3:0] i, input logic [7:0] d);
    set_ptr(i); wr(d);
  endtask

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      1: return 8'hFF;
      7: return 8'h01;
      10: return 8'h60;
      11: return 8'h12;
      12: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  task automatic sweep_defaults(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_at(i[3:0], tag, rst_val(i));
      check({tag, " R4 ptr"}, ptr, (i == 15) ? 15 : i + 1);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    automatic logic [3:0] trk[10] = '{4'd1, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14};
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    check("R1 ptr", ptr, 0);
    check("R1 busy", xfer_busy, 0);
    check("R1 host_end", host_end, 1);
    check("R1 outs", {xfer_cnt, xfer_addr}, 0);
    check("R1 ctrl", {sub_out, ctrl_out}, 0);
    sweep_defaults("R1 R2 read");

    // R3 R5 write map walk
    set_ptr(0);
    wr(8'hA5); check("R5 p0", ptr, 1);
    wr(8'h22); check("R5 p1", ptr, 2);
    wr(8'h34); check("R5 p2", ptr, 3);
    wr(8'h12); check("R5 p3", ptr, 4);
    wr(8'h78); check("R5 p4", ptr, 5);
    wr(8'h56); check("R5 p5", ptr, 6);
    set_ptr(8);
    wr(8'hCD); check("R5 p8", ptr, 9);
    wr(8'hAB); check("R5 p9", ptr, 10);
    wr(8'h80); check("R5 p10", ptr, 11);
    wr(8'h11); check("R5 p11", ptr, 12);
    wr(8'h9A); check("R5 p12", ptr, 13);
    wr(8'h02); check("R5 p13", ptr, 14);
    wr(8'h33); check("R5 p14", ptr, 14);
    check("R3 sub_out", sub_out, 8'hA5);
    check("R3 ctrl_out", ctrl_out, 24'h331180);
    check("R3 xfer_addr", xfer_addr, 16'h5678);
    check("R3 xfer_cnt", xfer_cnt, 16'h1234);
    check("R3 busy idle", xfer_busy, 0);
    rd_at(2, "R3 cnt lo", 8'h34);
    rd_at(3, "R3 cnt hi", 8'h12);
    rd_at(8, "R3 blk lo", 8'h9A);
    rd_at(9, "R3 blk hi", 8'h02);
    rd_at(10, "R3 wa lo", 8'hCD);
    rd_at(11, "R3 wa hi", 8'hAB);

    // R10 trigger
    wr_at(6, 8'h00);
    check("R5 p6", ptr, 6);
    check("R10 busy", xfer_busy, 1);
    check("R10 host_end", host_end, 0);
    rd_at(1, "R10 ifstat", 8'hF7);

    // R13 load, R11 ack
    dec_ld = 1; dec_cmd = 8'h3C; dec_ifstat = 8'h00;
    dec_head = 32'h4433_2211; dec_stat = 32'h0D0C_0B0A;
    tick(); dec_ld = 0;
    wr_at(7, 8'h00);
    check("R5 p7", ptr, 7);
    rd_at(1, "R11 ifstat", 8'h40);
    rd_at(0, "R13 cmd", 8'h3C);
    rd_at(4, "R13 h0", 8'h11);
    rd_at(5, "R13 h1", 8'h22);
    rd_at(6, "R13 h2", 8'h33);
    rd_at(7, "R13 h3", 8'h44);
    rd_at(12, "R13 s0", 8'h0A);
    rd_at(13, "R13 s1", 8'h0B);
    rd_at(14, "R13 s2", 8'h0C);
    // R7 R8: mask full, enables on
    rd_at(15, "R7 old s3", 8'h0D);
    rd("R7 valid s3", 8'h80, 1);
    check("R4 p15", ptr, 15);
    rd_at(1, "R8 ifstat", 8'h60);

    // R9 stop
    wr_at(1, 8'h20);
    check("R5 p1b", ptr, 2);
    check("R9 busy", xfer_busy, 0);
    check("R9 cnt", xfer_cnt, 0);
    rd_at(1, "R9 ifstat", 8'h68);
    // R10 trigger ignored when disabled
    wr_at(6, 8'h00);
    check("R10 no busy", xfer_busy, 0);
    rd_at(1, "R10 no ifstat", 8'h68);

    // R12 soft reset
    wr_at(15, 8'h00);
    check("R12 ptr", ptr, 15);
    check("R12 host_end kept", host_end, 0);
    check("R12 outs", {sub_out, ctrl_out, xfer_addr, xfer_cnt}, 0);
    sweep_defaults("R12 read");

    // R7 mask sweep: each tracked register left out once
    for (int m = 0; m < 10; m++) begin
      wr_at(15, 8'h00);
      wr_at(10, 8'h80);
      wr_at(1, 8'h22);
      for (int k = 0; k < 10; k++)
        if (k != m) begin set_ptr(trk[k]); rd("", 8'h00, 0); end
      rd_at(15, "R7 partial a", 8'h00);
      rd("R7 partial b", 8'h00, 1);
      set_ptr(trk[m]); rd("", 8'h00, 0);
      rd_at(15, "R7 full a", 8'h00);
      rd("R7 full b", 8'h80, 1);
    end

    // R7 enable gating
    wr_at(15, 8'h00);
    wr_at(1, 8'h22);
    for (int k = 0; k < 10; k++) begin set_ptr(trk[k]); rd("", 8'h00, 0); end
    rd_at(15, "R7 no ctrl0", 8'h00);
    rd("R7 no ctrl0 b", 8'h00, 1);
    wr_at(10, 8'h80);
    wr_at(1, 8'h02);
    rd_at(15, "R7 no ifctrl", 8'h00);
    rd("R7 no ifctrl b", 8'h00, 1);
    wr_at(1, 8'h22);
    rd_at(15, "R7 gate a", 8'h00);
    rd("R7 gate b", 8'h80, 1);

    // R6 read+write together: write wins
    set_ptr(12);
    rd_en = 1; wr_en = 1; wdata = 8'h5A; tick(); rd_en = 0; wr_en = 0;
    check("R6 rw ptr", ptr, 13);
    rd_at(8, "R6 rw data", 8'h5A);
    // R6 load wins over write
    set_ptr(2);
    ptr_ld = 1; ptr_val = 3; wr_en = 1; wdata = 8'hEE; tick();
    ptr_ld = 0; wr_en = 0;
    check("R6 ld ptr", ptr, 3);
    rd_at(2, "R6 ld no wr lo", 8'h00);
    rd_at(3, "R6 ld no wr hi", 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule